// File: doc/BRIEF.md
# Converter Link Reset Sequencer

This block takes several reset requests and merges them into one management reset: a push-button reset, a software reset level held in a control register, and the control logic's own reset. It then releases the resets of a converter-link subsystem one after another. The core PLL is released first. The memory-mapped configuration ports of the transmit and receive link cores follow. The SYSREF generator comes next, and the link and transport layers of each side come last. Every step is timed on a free-running management clock.

Two conditions gate the later outputs. The SYSREF reset and the link resets release only while the PLL reports lock. Each side's link reset also waits for that side's active-low reset acknowledge. If lock is lost while the subsystem is running, the SYSREF and link resets return to reset at once. The PLL and configuration resets stay released, and the sequence picks up again when lock returns. A side that waits longer than a programmable limit for its acknowledge raises a sticky timeout flag and stays in reset.

The sides are built by a generate loop, one channel per side, with two sides by default: transmit and receive.

Top module: `lnk_rst_sequencer`

## Requirements
- R1: `mgmt_rst_n` goes low asynchronously whenever `btn_rst_n` is low, `sw_rst` is high or `ctl_rst_n` is low. After all three go inactive it rises on the second rising clock edge.
- R2: `pll_rst` (active high) is 1 whenever `mgmt_rst_n` is 0. It falls on the first clock edge after `mgmt_rst_n` rises, before any other output releases.
- R3: Every bit of `cfg_rst_n` is 0 whenever `mgmt_rst_n` is 0. The bits rise exactly `GAP_CYC` (16) cycles after `pll_rst` falls.
- R4: `sysref_rst_n` rises only while synchronised lock is high, and no sooner than `GAP_CYC` cycles after `cfg_rst_n` rises. With lock already present it rises exactly 16 cycles after `cfg_rst_n`. While lock is absent it stays 0 indefinitely.
- R5: `link_rst_n[i]` rises only when lock is present and `link_ack_n[i]` is low. When the acknowledge is already present it rises 17 cycles after `sysref_rst_n`. The sides are independent: bit 0 is transmit, bit 1 is receive.
- R6: When `pll_locked` falls, `sysref_rst_n` and every `link_rst_n` bit go to 0 within two clock edges, while `pll_rst` stays 0 and `cfg_rst_n` stays all ones.
- R7: `ack_timeout[i]` sets after side i has spent more than `ack_limit` cycles in the link stage without an acknowledge. While it waits, `link_rst_n[i]` stays 0. The flag stays set even after the acknowledge arrives, and only the management reset clears it.
- R8: The software reset takes effect while `sw_rst` is 1 and is released by returning it to 0, provided the other sources are inactive. The full sequence then runs again.
- R9: The release order is fixed: `pll_rst`, then `cfg_rst_n`, then `sysref_rst_n`, then `link_rst_n`. Each release comes at least 16 cycles after the one before it.
- R10: After lock returns, `sysref_rst_n` rises again, and each acknowledged link rises 17 cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mgmt_clk | input | 1 | Free-running management clock |
| btn_rst_n | input | 1 | Push-button reset request, active low |
| sw_rst | input | 1 | Software reset level from a control register bit, active high |
| ctl_rst_n | input | 1 | Reset of the control logic, active low |
| pll_locked | input | 1 | Core PLL lock indication, asynchronous |
| link_ack_n | input | N_SIDES | Per-side reset acknowledge from the link core, active low |
| ack_limit | input | TO_W | Acknowledge wait limit in cycles |
| mgmt_rst_n | output | 1 | Combined management reset, active low |
| pll_rst | output | 1 | Core PLL reset, active high |
| cfg_rst_n | output | N_SIDES | Configuration-port resets, active low |
| sysref_rst_n | output | 1 | SYSREF generator reset, active low |
| link_rst_n | output | N_SIDES | Link and transport-layer resets, active low |
| ack_timeout | output | N_SIDES | Sticky acknowledge timeout flags |

## Verification
The bench stamps the cycle of every release and compares the gaps against exact values. A stage counter off by one, or a stage that skips its wait, shows up as a wrong spacing. Holding lock low for a long time would expose a SYSREF or link reset that released on timing alone, and dropping lock mid-run would expose a design that also pulled the PLL or configuration resets back, or kept the link running. Giving the two sides different acknowledges catches cross-coupled channels, a timeout flag that fires early, and one that clears itself or lets its link go.

// File: rtl/lnk_rst_pkg.sv
package lnk_rst_pkg;
   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_PLL   = 3'd1,
      ST_CFG   = 3'd2,
      ST_WLOCK = 3'd3,
      ST_SYS   = 3'd4,
      ST_LINK  = 3'd5
   } seq_st_t;
endpackage

// File: rtl/lrs_sync.sv
module lrs_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lrs_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d};
   end

   assign q = sr[STAGES-1];
endmodule

// File: rtl/lrs_rst_comb.sv
module lrs_rst_comb #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic btn_rst_n,
   input  logic sw_rst,
   input  logic ctl_rst_n,
   output logic mrst_n
);
   logic src_n;

   // any active source clears the synchroniser at once; release is clocked
   assign src_n = btn_rst_n & ctl_rst_n & ~sw_rst;

   lrs_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_rel (
      .clk   (clk),
      .rst_n (src_n),
      .d     (1'b1),
      .q     (mrst_n)
   );

   always @(posedge clk) begin
      if (!src_n) begin
         a_r1_source_holds: assert (!mrst_n)
            else $error("R1: management reset released while a source is active");
      end
   end
endmodule

// File: rtl/lrs_fsm.sv
module lrs_fsm
   import lnk_rst_pkg::*;
#(
   parameter int GAP_CYC = 16
) (
   input  logic clk,
   input  logic mrst_n,
   input  logic lock_s,
   output logic pll_rel,
   output logic cfg_rel,
   output logic sys_stage,
   output logic in_link
);
   localparam int GW = $clog2(GAP_CYC + 1);

   seq_st_t         st, st_nx;
   logic [GW-1:0]   gcnt;
   logic            gap_done;

   assign gap_done = (gcnt == GW'(GAP_CYC - 1));

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_HOLD:  st_nx = ST_PLL;
         ST_PLL:   if (gap_done) st_nx = ST_CFG;
         ST_CFG:   if (gap_done) st_nx = lock_s ? ST_SYS : ST_WLOCK;
         ST_WLOCK: if (lock_s)   st_nx = ST_SYS;
         ST_SYS: begin
            if (!lock_s)       st_nx = ST_WLOCK;
            else if (gap_done) st_nx = ST_LINK;
         end
         ST_LINK:  if (!lock_s)  st_nx = ST_WLOCK;
         default:  st_nx = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
         st   <= ST_HOLD;
         gcnt <= '0;
      end else begin
         st   <= st_nx;
         gcnt <= (st_nx != st) ? '0 : gcnt + 1'b1;
      end
   end

   assign pll_rel   = (st != ST_HOLD);
   assign cfg_rel   = (st != ST_HOLD) && (st != ST_PLL);
   assign sys_stage = (st == ST_SYS) || (st == ST_LINK);
   assign in_link   = (st == ST_LINK);

   a_r9_sys_after_cfg: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(sys_stage) |-> (cfg_rel && $past(cfg_rel)))
      else $error("R9: SYSREF stage entered without configuration released");
endmodule

// File: rtl/lrs_link_chan.sv
module lrs_link_chan #(
   parameter int STAGES = 2,
   parameter int TO_W   = 16
) (
   input  logic            clk,
   input  logic            mrst_n,
   input  logic            in_link,
   input  logic            lock_s,
   input  logic            ack_raw_n,
   input  logic [TO_W-1:0] ack_limit,
   output logic            link_rst_n,
   output logic            timeout
);
   logic            ack_s;
   logic            link_rel;
   logic            waiting;
   logic [TO_W-1:0] wcnt;

   lrs_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_ack (
      .clk   (clk),
      .rst_n (mrst_n),
      .d     (~ack_raw_n),
      .q     (ack_s)
   );

   assign waiting = in_link && !link_rel && !ack_s;

   always_ff @(posedge clk or negedge mrst_n) begin
      if (!mrst_n) begin
         link_rel <= 1'b0;
         wcnt     <= '0;
         timeout  <= 1'b0;
      end else begin
         if (!in_link)    link_rel <= 1'b0;
         else if (ack_s)  link_rel <= 1'b1;
         if (!waiting)         wcnt <= '0;
         else if (wcnt != '1)  wcnt <= wcnt + 1'b1;
         if (waiting && (wcnt >= ack_limit)) timeout <= 1'b1;
      end
   end

   assign link_rst_n = link_rel & lock_s;

   a_r5_needs_ack: assert property (@(posedge clk) disable iff (!mrst_n)
      $rose(link_rst_n) |-> $past(ack_s))
      else $error("R5: link released without acknowledge");

   a_r7_sticky: assert property (@(posedge clk) disable iff (!mrst_n)
      timeout |=> timeout)
      else $error("R7: timeout flag cleared without reset");
endmodule

// File: rtl/lnk_rst_sequencer.sv
module lnk_rst_sequencer #(
   parameter int N_SIDES     = 2,
   parameter int SYNC_STAGES = 2,
   parameter int GAP_CYC     = 16,
   parameter int TO_W        = 16
) (
   input  logic               mgmt_clk,
   input  logic               btn_rst_n,
   input  logic               sw_rst,
   input  logic               ctl_rst_n,
   input  logic               pll_locked,
   input  logic [N_SIDES-1:0] link_ack_n,
   input  logic [TO_W-1:0]    ack_limit,
   output logic               mgmt_rst_n,
   output logic               pll_rst,
   output logic [N_SIDES-1:0] cfg_rst_n,
   output logic               sysref_rst_n,
   output logic [N_SIDES-1:0] link_rst_n,
   output logic [N_SIDES-1:0] ack_timeout
);
   generate
      if (N_SIDES < 1) begin : g_bad_sides
         $error("lnk_rst_sequencer: N_SIDES must be at least 1");
      end
      if (GAP_CYC < 16) begin : g_bad_gap
         $error("lnk_rst_sequencer: GAP_CYC must be at least 16");
      end
      if (TO_W < 2) begin : g_bad_tow
         $error("lnk_rst_sequencer: TO_W must be at least 2");
      end
   endgenerate

   logic mrst_n;
   logic lock_s;
   logic pll_rel, cfg_rel, sys_stage, in_link;

   lrs_rst_comb #(.STAGES(SYNC_STAGES)) u_comb (
      .clk       (mgmt_clk),
      .btn_rst_n (btn_rst_n),
      .sw_rst    (sw_rst),
      .ctl_rst_n (ctl_rst_n),
      .mrst_n    (mrst_n)
   );

   lrs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock (
      .clk   (mgmt_clk),
      .rst_n (mrst_n),
      .d     (pll_locked),
      .q     (lock_s)
   );

   lrs_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
      .clk       (mgmt_clk),
      .mrst_n    (mrst_n),
      .lock_s    (lock_s),
      .pll_rel   (pll_rel),
      .cfg_rel   (cfg_rel),
      .sys_stage (sys_stage),
      .in_link   (in_link)
   );

   assign mgmt_rst_n   = mrst_n;
   assign pll_rst      = ~pll_rel;
   assign cfg_rst_n    = {N_SIDES{cfg_rel}};
   assign sysref_rst_n = sys_stage & lock_s;

   generate
      for (genvar g = 0; g < N_SIDES; g++) begin : g_side
         lrs_link_chan #(.STAGES(SYNC_STAGES), .TO_W(TO_W)) u_chan (
            .clk        (mgmt_clk),
            .mrst_n     (mrst_n),
            .in_link    (in_link),
            .lock_s     (lock_s),
            .ack_raw_n  (link_ack_n[g]),
            .ack_limit  (ack_limit),
            .link_rst_n (link_rst_n[g]),
            .timeout    (ack_timeout[g])
         );
      end
   endgenerate

   always @(posedge mgmt_clk) begin
      if (!mrst_n) begin
         a_r2_pll_in_reset: assert (pll_rst && cfg_rst_n == '0)
            else $error("R2: PLL or configuration released during management reset");
      end
   end

   a_r6_lock_drop: assert property (@(posedge mgmt_clk) disable iff (!mrst_n)
      !lock_s |-> (!sysref_rst_n && link_rst_n == '0))
      else $error("R6: SYSREF or link released without lock");

   a_r4_sys_after_cfg: assert property (@(posedge mgmt_clk) disable iff (!mrst_n)
      $rose(sysref_rst_n) |-> (cfg_rst_n == '1 && !pll_rst))
      else $error("R4: SYSREF released before earlier stages");
endmodule

// File: tb/lnk_rst_sequencer_test.sv
module lnk_rst_sequencer_test;
   logic        clk = 1'b0;
   logic        btn_n, sw, ctl_n, lock;
   logic [1:0]  ack_n;
   logic [15:0] ack_lim;
   logic        mgmt_rst_n, pll_rst, sysref_rst_n;
   logic [1:0]  cfg_rst_n, link_rst_n, ack_timeout;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int t_rel, t_mg, t_pll, t_cfg, t_sys, t_lk0, t_lk1;
   logic p_mg = 1'b0, p_pll = 1'b1, p_cfg = 1'b0, p_sys = 1'b0, p_lk0 = 1'b0, p_lk1 = 1'b0;

   always #2 clk = ~clk;

   lnk_rst_sequencer uut (
      .mgmt_clk     (clk),
      .btn_rst_n    (btn_n),
      .sw_rst       (sw),
      .ctl_rst_n    (ctl_n),
      .pll_locked   (lock),
      .link_ack_n   (ack_n),
      .ack_limit    (ack_lim),
      .mgmt_rst_n   (mgmt_rst_n),
      .pll_rst      (pll_rst),
      .cfg_rst_n    (cfg_rst_n),
      .sysref_rst_n (sysref_rst_n),
      .link_rst_n   (link_rst_n),
      .ack_timeout  (ack_timeout)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!p_mg && mgmt_rst_n)       t_mg  = cyc;
      if (p_pll && !pll_rst)         t_pll = cyc;
      if (!p_cfg && cfg_rst_n[0])    t_cfg = cyc;
      if (!p_sys && sysref_rst_n)    t_sys = cyc;
      if (!p_lk0 && link_rst_n[0])   t_lk0 = cyc;
      if (!p_lk1 && link_rst_n[1])   t_lk1 = cyc;
      p_mg = mgmt_rst_n; p_pll = pll_rst; p_cfg = cfg_rst_n[0];
      p_sys = sysref_rst_n; p_lk0 = link_rst_n[0]; p_lk1 = link_rst_n[1];
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_stamps();
      t_rel = -1; t_mg = -1; t_pll = -1; t_cfg = -1; t_sys = -1; t_lk0 = -1; t_lk1 = -1;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic full_reset_release();
      @(negedge clk);
      btn_n = 1'b0;
      cycles(3);
      clear_stamps();
      btn_n = 1'b1;
      t_rel = cyc;
   endtask

   task automatic t_reset_state();
      cycles(4);
      check("R1 mgmt reset while button held", mgmt_rst_n, 0);
      check("R2 pll reset while held", pll_rst, 1);
      check("R3 cfg reset while held", cfg_rst_n, 0);
      check("R4 sysref reset while held", sysref_rst_n, 0);
      check("R5 link reset while held", link_rst_n, 0);
      check("R7 timeout clear at reset", ack_timeout, 0);
   endtask

   task automatic t_sequence();
      lock = 1'b1; ack_n = 2'b00; ack_lim = 16'd1000;
      full_reset_release();
      cycles(80);
      check("R1 mgmt release latency", t_mg - t_rel, 2);
      check("R2 pll release after mgmt", t_pll - t_mg, 1);
      check("R3 cfg gap after pll", t_cfg - t_pll, 16);
      check("R4 sysref gap after cfg", t_sys - t_cfg, 16);
      check("R5 link0 gap after sysref", t_lk0 - t_sys, 17);
      check("R5 link1 gap after sysref", t_lk1 - t_sys, 17);
      check("R9 ordered gaps", int'((t_cfg - t_pll >= 16) && (t_sys - t_cfg >= 16) && (t_lk0 - t_sys >= 16)), 1);
      check("R7 no timeout when acked", ack_timeout, 0);
   endtask

   task automatic t_sources();
      @(negedge clk); ctl_n = 1'b0; #1;
      check("R1 ctl source async", mgmt_rst_n, 0);
      check("R2 pll reset follows ctl", pll_rst, 1);
      check("R5 link reset follows ctl", link_rst_n, 0);
      @(negedge clk); ctl_n = 1'b1;
      cycles(3);
      @(negedge clk); sw = 1'b1; #1;
      check("R8 sw bit asserts reset", mgmt_rst_n, 0);
      check("R3 cfg reset follows sw", cfg_rst_n, 0);
      cycles(5);
      check("R8 reset held while sw set", mgmt_rst_n, 0);
      clear_stamps();
      sw = 1'b0; t_rel = cyc;
      cycles(80);
      check("R8 sw clear releases mgmt", t_mg - t_rel, 2);
      check("R8 sequence reruns to link", link_rst_n, 3);
      @(negedge clk); btn_n = 1'b0; #1;
      check("R1 button source async", mgmt_rst_n, 0);
      check("R4 sysref follows button", sysref_rst_n, 0);
      @(negedge clk); btn_n = 1'b1;
      cycles(80);
   endtask

   task automatic t_lock_wait();
      lock = 1'b0; ack_n = 2'b00;
      full_reset_release();
      cycles(70);
      check("R3 cfg released without lock", cfg_rst_n, 3);
      check("R4 sysref held without lock", sysref_rst_n, 0);
      check("R5 link held without lock", link_rst_n, 0);
      lock = 1'b1;
      cycles(4);
      check("R4 sysref after lock arrives", sysref_rst_n, 1);
      cycles(20);
      check("R5 link after lock arrives", link_rst_n, 3);
   endtask

   task automatic t_lock_loss();
      @(negedge clk); lock = 1'b0;
      cycles(2);
      check("R6 sysref reasserts", sysref_rst_n, 0);
      check("R6 link reasserts", link_rst_n, 0);
      check("R6 pll stays released", pll_rst, 0);
      check("R6 cfg stays released", cfg_rst_n, 3);
      cycles(10);
      clear_stamps();
      lock = 1'b1;
      cycles(40);
      check("R10 sysref re-released", int'(t_sys >= 0), 1);
      check("R10 link gap after relock", t_lk0 - t_sys, 17);
      check("R10 mgmt untouched by lock", int'(t_mg < 0 && mgmt_rst_n), 1);
   endtask

   task automatic t_timeout();
      lock = 1'b1; ack_n = 2'b10; ack_lim = 16'd20;
      full_reset_release();
      for (int i = 0; i < 200 && t_sys < 0; i++) @(negedge clk);
      cycles(26);
      check("R7 no early timeout", ack_timeout, 0);
      check("R5 side0 independent", link_rst_n, 1);
      cycles(20);
      check("R7 timeout on side1", ack_timeout, 2);
      check("R7 side1 held in reset", link_rst_n[1], 0);
      ack_n = 2'b00;
      cycles(6);
      check("R5 side1 released after ack", link_rst_n, 3);
      check("R7 timeout sticky", ack_timeout, 2);
      @(negedge clk); sw = 1'b1;
      cycles(2);
      check("R7 timeout cleared by reset", ack_timeout, 0);
      sw = 1'b0;
      cycles(80);
      check("R7 stays clear with ack", ack_timeout, 0);
   endtask

   initial begin
      btn_n = 1'b0; sw = 1'b0; ctl_n = 1'b1; lock = 1'b0; ack_n = 2'b11; ack_lim = 16'd1000;
      clear_stamps();
      t_reset_state();
      t_sequence();
      t_sources();
      t_lock_wait();
      t_lock_loss();
      t_timeout();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule